// File: doc/BRIEF.md
# UART-compatible host register window

This block is the register side of a 16550-style serial port. A host reaches it through an eight-byte window, one byte per access. Within that window it finds the divisor latch, interrupt enable, line control, modem control, line status, modem status and scratch registers, and an interrupt identification register. Bit-level serialisation and baud timing are left to other logic.

Bytes the host writes to the data offset leave on a valid/ready transmit stream. In loopback mode they are steered back into the receive queue instead. Bytes arriving on the receive stream are queued for the host to read at the data offset. Every receive-available or holding-empty event loads an identification code and emits a single-cycle interrupt pulse. Reading the identification register hands back the current code and then returns it to "nothing pending".

Top module: `uart_regwin`

## Requirements
- R1: After reset, offset 3 reads 0x03, offset 5 reads 0x60, offset 2 reads 0x01, and offsets 1, 4, 6 and 7 read 0x00. The divisor is 0x0000, the receive queue is empty so offset 0 reads 0xFF, and `tx_valid` and `irq` are low.
- R2: The window has fixed offsets: 0 data, 1 interrupt enable, 2 identification (read) or FIFO control (write), 3 line control, 4 modem control, 5 line status, 6 modem status, 7 scratch. Line control, modem control and scratch store and return any written byte. Writes to offsets 2, 5 and 6 change nothing, and offset 6 reads 0x00.
- R3: Interrupt enable keeps only bits 3:0 of a write: bit 0 is receive available, bit 1 is holding empty, and bits 2 and 3 are stored only. Bits 7:4 always read back as zero.
- R4: While line control bit 7 is set, offsets 0 and 1 read and write the low and high divisor bytes. Such accesses neither pop the queue, transmit, nor touch interrupt enable.
- R5: With modem control bit 4 clear, a write to offset 0 presents the byte on `tx_data` with `tx_valid` high from the next cycle. The byte is held until a cycle with `tx_ready` high. A new write while a byte is still pending replaces it.
- R6: With modem control bit 4 set, a write to offset 0 appends the byte to the receive queue and sets line status bit 0. Nothing is sent on the transmit stream.
- R7: The receive queue holds 16 bytes. A receive byte is taken when `rx_valid` and `rx_ready` are both high. `rx_ready` is low while the queue is full and in any cycle carrying a loopback write. A loopback write into a full queue is discarded and raises no event.
- R8: A non-divisor read of offset 0 returns the oldest queued byte and removes it, or returns 0xFF when the queue is empty. If the queue held one byte or none before the read, line status bit 0 clears, unless a byte is queued in that same cycle.
- R9: A queued byte with enable bit 0 set sets the identification low nibble to 0100. A non-loopback transmit write with enable bit 1 set sets it to 0010. When both happen in one cycle, 0100 wins. `irq` is high for exactly the cycle after each cycle with an event.
- R10: A read of offset 2 returns the current identification value with bits 7:4 zero and then sets the low nibble to 0001. An event in the same cycle as the read leaves the new code in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Host access strobe, one access per cycle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 3 | Byte offset in the window |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Read byte, valid in the cycle of a read access |
| rx_valid | input | 1 | Receive stream byte valid |
| rx_data | input | 8 | Receive stream byte |
| rx_ready | output | 1 | Receive stream can take a byte |
| tx_valid | output | 1 | Transmit stream byte valid |
| tx_data | output | 8 | Transmit stream byte |
| tx_ready | input | 1 | Transmit sink takes the byte |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench fills the receive queue past sixteen bytes and then tries a loopback write into the full queue. A design that overwrote its oldest entry would return wrong bytes, and one that pulsed anyway would show a spurious `irq`. It reads the identification register in the same cycle that a byte arrives; a design that cleared after applying the event would lose the 0100 code. It reads offset 0 with one byte queued while another arrives, which catches a design that drops line status bit 0 although data remains. It also reads offset 0 in divisor mode, where a design that popped the queue would return the divisor but then come up one byte short.

// File: rtl/uart_regwin_pkg.sv
package uart_regwin_pkg;

    localparam logic [2:0] ADR_DATA    = 3'd0;
    localparam logic [2:0] ADR_IEN     = 3'd1;
    localparam logic [2:0] ADR_IDENT   = 3'd2;
    localparam logic [2:0] ADR_LCTL    = 3'd3;
    localparam logic [2:0] ADR_MCTL    = 3'd4;
    localparam logic [2:0] ADR_LSTAT   = 3'd5;
    localparam logic [2:0] ADR_MSTAT   = 3'd6;
    localparam logic [2:0] ADR_SCRATCH = 3'd7;

    localparam int unsigned LCTL_DIV_BIT  = 7;
    localparam int unsigned MCTL_LOOP_BIT = 4;
    localparam int unsigned IEN_RXAV_BIT  = 0;
    localparam int unsigned IEN_TXE_BIT   = 1;

    localparam logic [3:0] IID_NONE = 4'b0001;
    localparam logic [3:0] IID_RXAV = 4'b0100;
    localparam logic [3:0] IID_TXE  = 4'b0010;

    localparam logic [7:0] LCTL_RESET  = 8'h03;
    localparam logic [7:0] LSTAT_FIXED = 8'h60;
    localparam logic [7:0] EMPTY_READ  = 8'hFF;

    typedef struct packed {
        logic [3:0] ien;
        logic [7:0] lctl;
        logic [7:0] mctl;
        logic [7:0] scratch;
        logic [7:0] div_lo;
        logic [7:0] div_hi;
        logic       data_rdy;
    } regs_t;

    typedef struct packed {
        logic [3:0] code;
        logic       irq;
    } iid_state_t;

    typedef struct packed {
        logic       valid;
        logic [7:0] data;
    } tx_state_t;

endpackage

// File: rtl/uart_rxq.sv
module uart_rxq #(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned DW     = 8,
    parameter int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [DW-1:0]    push_data,
    input  logic             pop,
    output logic [DW-1:0]    head,
    output logic             empty,
    output logic             full,
    output logic [CNT_W-1:0] count
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [AW-1:0]    wr_ptr;
        logic [AW-1:0]    rd_ptr;
        logic [CNT_W-1:0] cnt;
    } ptr_state_t;

    ptr_state_t st_d, st_q;
    logic [DW-1:0] mem_q [DEPTH];

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CNT_W'(DEPTH));
    assign count = st_q.cnt;
    assign head  = mem_q[st_q.rd_ptr];

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.wr_ptr = ptr_inc(st_q.wr_ptr);
        end
        if (pop) begin
            st_d.rd_ptr = ptr_inc(st_q.rd_ptr);
        end
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + CNT_W'(1);
            2'b01:   st_d.cnt = st_q.cnt - CNT_W'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            mem_q[st_q.wr_ptr] <= push_data;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);  // R7
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !pop);  // R8
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH));  // R7

endmodule

// File: rtl/uart_iid.sv
module uart_iid
    import uart_regwin_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_clr,
    input  logic       ev_rx,
    input  logic       ev_tx,
    output logic [3:0] code,
    output logic       irq
);
    iid_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = ev_rx | ev_tx;
        if (rd_clr) begin
            st_d.code = IID_NONE;
        end
        if (ev_tx) begin
            st_d.code = IID_TXE;
        end
        if (ev_rx) begin
            st_d.code = IID_RXAV;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{code: IID_NONE, irq: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign code = st_q.code;
    assign irq  = st_q.irq;

    AST_IID_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.code == IID_NONE) || (st_q.code == IID_RXAV) || (st_q.code == IID_TXE));  // R9
    AST_IID_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !ev_rx && !ev_tx) |=> (code == IID_NONE));  // R10
    AST_IRQ_FOLLOWS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rx || ev_tx) |=> irq);  // R9
    AST_IRQ_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_rx && !ev_tx) |=> !irq);  // R9

endmodule

// File: rtl/uart_txhold.sv
module uart_txhold
    import uart_regwin_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] load_data,
    input  logic       tx_ready,
    output logic       tx_valid,
    output logic [7:0] tx_data
);
    tx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.valid = 1'b1;
            st_d.data  = load_data;
        end else if (tx_ready) begin
            st_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_valid = st_q.valid;
    assign tx_data  = st_q.data;

    AST_TX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !load) |=> (tx_valid && $stable(tx_data)));  // R5
    AST_TX_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> tx_valid);  // R5

endmodule

// File: rtl/uart_regwin.sv
module uart_regwin
    import uart_regwin_pkg::*;
#(
    parameter int unsigned RXQ_DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_sel,
    input  logic       host_wr,
    input  logic [2:0] host_addr,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    output logic       rx_ready,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    input  logic       tx_ready,
    output logic       irq
);
    localparam int unsigned CNT_W = $clog2(RXQ_DEPTH + 1);

    regs_t regs_d, regs_q;

    logic             rd_acc, wr_acc;
    logic             div_mode, loop_mode;
    logic             data_wr, lb_wr, tx_wr, data_rd, ident_rd;
    logic             rx_take, lb_take, q_push, q_pop;
    logic [7:0]       q_push_data, q_head;
    logic             q_empty, q_full;
    logic [CNT_W-1:0] q_count;
    logic             ev_rx, ev_tx;
    logic [3:0]       iid_code;

    // access decode
    assign rd_acc    = host_sel & ~host_wr;
    assign wr_acc    = host_sel & host_wr;
    assign div_mode  = regs_q.lctl[LCTL_DIV_BIT];
    assign loop_mode = regs_q.mctl[MCTL_LOOP_BIT];
    assign data_wr   = wr_acc & (host_addr == ADR_DATA) & ~div_mode;
    assign lb_wr     = data_wr & loop_mode;
    assign tx_wr     = data_wr & ~loop_mode;
    assign data_rd   = rd_acc & (host_addr == ADR_DATA) & ~div_mode;
    assign ident_rd  = rd_acc & (host_addr == ADR_IDENT);

    // receive queue feed: loopback write owns the push port in its cycle
    assign rx_ready    = ~q_full & ~lb_wr;
    assign rx_take     = rx_valid & rx_ready;
    assign lb_take     = lb_wr & ~q_full;
    assign q_push      = rx_take | lb_take;
    assign q_push_data = lb_take ? host_wdata : rx_data;
    assign q_pop       = data_rd & ~q_empty;

    // interrupt events
    assign ev_rx = q_push & regs_q.ien[IEN_RXAV_BIT];
    assign ev_tx = tx_wr & regs_q.ien[IEN_TXE_BIT];

    uart_rxq #(
        .DEPTH (RXQ_DEPTH),
        .DW    (8),
        .CNT_W (CNT_W)
    ) i_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (q_push),
        .push_data (q_push_data),
        .pop       (q_pop),
        .head      (q_head),
        .empty     (q_empty),
        .full      (q_full),
        .count     (q_count)
    );

    uart_iid i_iid (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_clr (ident_rd),
        .ev_rx  (ev_rx),
        .ev_tx  (ev_tx),
        .code   (iid_code),
        .irq    (irq)
    );

    uart_txhold i_txhold (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (tx_wr),
        .load_data (host_wdata),
        .tx_ready  (tx_ready),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data)
    );

    // next register state
    always_comb begin
        regs_d = regs_q;
        if (data_rd && (q_count <= CNT_W'(1))) begin
            regs_d.data_rdy = 1'b0;
        end
        if (q_push) begin
            regs_d.data_rdy = 1'b1;
        end
        if (wr_acc) begin
            case (host_addr)
                ADR_DATA: begin
                    if (div_mode) regs_d.div_lo = host_wdata;
                end
                ADR_IEN: begin
                    if (div_mode) regs_d.div_hi = host_wdata;
                    else          regs_d.ien    = host_wdata[3:0];
                end
                ADR_LCTL:    regs_d.lctl    = host_wdata;
                ADR_MCTL:    regs_d.mctl    = host_wdata;
                ADR_SCRATCH: regs_d.scratch = host_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '{ien: 4'h0, lctl: LCTL_RESET, mctl: 8'h00, scratch: 8'h00,
                        div_lo: 8'h00, div_hi: 8'h00, data_rdy: 1'b0};
        end else begin
            regs_q <= regs_d;
        end
    end

    // read mux
    always_comb begin
        case (host_addr)
            ADR_DATA:    host_rdata = div_mode ? regs_q.div_lo
                                               : (q_empty ? EMPTY_READ : q_head);
            ADR_IEN:     host_rdata = div_mode ? regs_q.div_hi : {4'h0, regs_q.ien};
            ADR_IDENT:   host_rdata = {4'h0, iid_code};
            ADR_LCTL:    host_rdata = regs_q.lctl;
            ADR_MCTL:    host_rdata = regs_q.mctl;
            ADR_LSTAT:   host_rdata = LSTAT_FIXED | {7'h00, regs_q.data_rdy};
            ADR_MSTAT:   host_rdata = 8'h00;
            default:     host_rdata = regs_q.scratch;
        endcase
    end

    AST_DR_MATCHES_QUEUE: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q.data_rdy == !q_empty);  // R8
    AST_FULL_BLOCKS_RX: assert property (@(posedge clk) disable iff (!rst_n)
        q_full |-> !rx_ready);  // R7
    AST_LOOP_NO_TX: assert property (@(posedge clk) disable iff (!rst_n)
        (lb_wr && !tx_valid) |=> !tx_valid);  // R6
    AST_DIV_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && div_mode && !q_push) |=> $stable(q_count));  // R4

endmodule

// File: tb/test_uart_regwin.sv
`timescale 1ns/1ps
module test_uart_regwin;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_sel = 1'b0, host_wr = 1'b0;
    logic [2:0] host_addr = 3'd0;
    logic [7:0] host_wdata = 8'h00, host_rdata;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       rx_ready, tx_valid, irq;
    logic [7:0] tx_data;
    logic       tx_ready = 1'b1;

    int total = 0;
    int bad   = 0;

    // reference model state
    logic [7:0] m_q[$];
    logic [3:0] m_ien = 4'h0, m_iid = 4'h1;
    logic [7:0] m_lcr = 8'h03, m_mcr = 8'h00, m_scr = 8'h00, m_dll = 8'h00, m_dlm = 8'h00;
    logic       m_dr = 1'b0, m_txv = 1'b0, m_irq = 1'b0;
    logic [7:0] m_txd = 8'h00;

    always #2 clk = ~clk;

    uart_regwin i_uart_regwin (
        .clk(clk), .rst_n(rst_n),
        .host_sel(host_sel), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .irq(irq)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] model_read(input logic [2:0] a);
        logic dl = m_lcr[7];
        case (a)
            3'd0: return dl ? m_dll : ((m_q.size() != 0) ? m_q[0] : 8'hFF);
            3'd1: return dl ? m_dlm : {4'h0, m_ien};
            3'd2: return {4'h0, m_iid};
            3'd3: return m_lcr;
            3'd4: return m_mcr;
            3'd5: return 8'h60 | {7'h0, m_dr};
            3'd6: return 8'h00;
            default: return m_scr;
        endcase
    endfunction

    // one clock of stimulus, comparison and model update
    task automatic cyc(input logic sel, input logic wr, input logic [2:0] a, input logic [7:0] wd,
                       input logic rxv, input logic [7:0] rxd, input string tag);
        logic dl, lb, lbwr, txwr, exp_rdy, take, ev_rx, ev_tx;
        @(negedge clk);
        host_sel = sel; host_wr = wr; host_addr = a; host_wdata = wd;
        rx_valid = rxv; rx_data = rxd;
        #1;
        dl = m_lcr[7];
        lb = m_mcr[4];
        lbwr = sel && wr && (a == 3'd0) && !dl && lb;
        txwr = sel && wr && (a == 3'd0) && !dl && !lb;
        exp_rdy = (m_q.size() < 16) && !lbwr;
        chk({7'h0, rx_ready}, {7'h0, exp_rdy}, "R7", "rx_ready");
        if (sel && !wr) chk(host_rdata, model_read(a), tag, "host_rdata");
        // model update
        ev_rx = 1'b0;
        ev_tx = 1'b0;
        take = rxv && exp_rdy;
        if (sel && !wr && (a == 3'd0) && !dl) begin
            if (m_q.size() <= 1) m_dr = 1'b0;
            if (m_q.size() != 0) void'(m_q.pop_front());
        end
        if (take) begin
            m_q.push_back(rxd); m_dr = 1'b1; ev_rx = m_ien[0];
        end
        if (lbwr && (m_q.size() < 16)) begin
            m_q.push_back(wd); m_dr = 1'b1; ev_rx = m_ien[0];
        end
        if (txwr) begin
            m_txv = 1'b1; m_txd = wd; ev_tx = m_ien[1];
        end else if (tx_ready) begin
            m_txv = 1'b0;
        end
        if (sel && !wr && (a == 3'd2)) m_iid = 4'h1;
        if (ev_tx) m_iid = 4'h2;
        if (ev_rx) m_iid = 4'h4;
        m_irq = ev_rx || ev_tx;
        if (sel && wr) begin
            case (a)
                3'd0: if (dl) m_dll = wd;
                3'd1: if (dl) m_dlm = wd; else m_ien = wd[3:0];
                3'd3: m_lcr = wd;
                3'd4: m_mcr = wd;
                3'd7: m_scr = wd;
                default: ;
            endcase
        end
        @(posedge clk);
        #1;
        chk({7'h0, tx_valid}, {7'h0, m_txv}, "R5", "tx_valid");
        if (m_txv) chk(tx_data, m_txd, "R5", "tx_data");
        chk({7'h0, irq}, {7'h0, m_irq}, "R9", "irq");
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        cyc(1'b1, 1'b1, a, d, 1'b0, 8'h00, "R2");
    endtask
    task automatic rd(input logic [2:0] a, input string tag);
        cyc(1'b1, 1'b0, a, 8'h00, 1'b0, 8'h00, tag);
    endtask
    task automatic idle();
        cyc(1'b0, 1'b0, 3'd0, 8'h00, 1'b0, 8'h00, "R2");
    endtask
    task automatic rxb(input logic [7:0] d);
        cyc(1'b0, 1'b0, 3'd0, 8'h00, 1'b1, d, "R7");
    endtask

    initial begin
        #(4 * 200000);
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values, including tx_valid and irq
        total++;
        if (tx_valid !== 1'b0 || irq !== 1'b0) begin
            bad++;
            $display("FAIL R1 outputs: got %b%b expected 00", tx_valid, irq);
        end
        for (int a = 0; a < 8; a++) rd(3'(a), "R1");
        // R2 plain registers and ignored writes
        wr(3'd7, 8'hA5); rd(3'd7, "R2");
        wr(3'd3, 8'h1B); rd(3'd3, "R2");
        wr(3'd4, 8'h0F); rd(3'd4, "R2");
        wr(3'd2, 8'hC7); wr(3'd5, 8'h00); wr(3'd6, 8'hFF);
        rd(3'd2, "R2"); rd(3'd5, "R2"); rd(3'd6, "R2");
        wr(3'd3, 8'h03); wr(3'd4, 8'h00);
        // R3 enable truncation
        wr(3'd1, 8'hFF); rd(3'd1, "R3");
        wr(3'd1, 8'h00);
        // R4 divisor latch
        wr(3'd3, 8'h83); wr(3'd0, 8'h34); wr(3'd1, 8'h12);
        rd(3'd0, "R4"); rd(3'd1, "R4");
        wr(3'd3, 8'h03); rd(3'd1, "R4");
        // R5 transmit path with back-pressure and replacement
        tx_ready = 1'b0;
        wr(3'd1, 8'h02);
        wr(3'd0, 8'h41); idle(); wr(3'd0, 8'h42); idle();
        rd(3'd2, "R10"); rd(3'd2, "R10");
        tx_ready = 1'b1;
        idle(); idle();
        // R6 loopback, R8 read order and empty read
        wr(3'd4, 8'h10); wr(3'd1, 8'h01);
        wr(3'd0, 8'h55); wr(3'd0, 8'h66);
        rd(3'd5, "R6"); rd(3'd2, "R9");
        rd(3'd0, "R8"); rd(3'd5, "R8"); rd(3'd0, "R8"); rd(3'd5, "R8"); rd(3'd0, "R8");
        // R7 fill past depth, loopback into full queue
        for (int i = 0; i < 18; i++) rxb(8'(8'h80 + i));
        wr(3'd0, 8'hEE);
        // R4 divisor read does not pop
        wr(3'd3, 8'h83); rd(3'd0, "R4"); wr(3'd3, 8'h03);
        for (int i = 0; i < 17; i++) rd(3'd0, "R8");
        rd(3'd5, "R8");
        // R10 identification read in same cycle as arriving byte
        wr(3'd4, 8'h00);
        rd(3'd2, "R10");
        cyc(1'b1, 1'b0, 3'd2, 8'h00, 1'b1, 8'h11, "R10");
        rd(3'd2, "R10"); rd(3'd2, "R10");
        // R8 last byte read while a new one arrives
        cyc(1'b1, 1'b0, 3'd0, 8'h00, 1'b1, 8'h22, "R8");
        rd(3'd5, "R8"); rd(3'd0, "R8"); rd(3'd5, "R8");
        // R9 transmit and receive events together
        wr(3'd1, 8'h03);
        cyc(1'b1, 1'b1, 3'd0, 8'h77, 1'b1, 8'h33, "R9");
        rd(3'd2, "R9"); rd(3'd0, "R9");
        // R9 transmit event alone, then no enable means no pulse
        wr(3'd0, 8'h78); rd(3'd2, "R9");
        wr(3'd1, 8'h00); wr(3'd0, 8'h79); rxb(8'h44); rd(3'd2, "R9");
        idle();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule